// File: doc/BRIEF.md
# SPI Receive FIFO and Status Unit

This block sits on the receive side of an SPI peripheral, between the serial shift engine and the register bus. It collects finished bytes in a four-entry first-in first-out store and hands them to the reader in arrival order. It also keeps a 16-bit status word and drives one level-sensitive interrupt line.

The status word reports how many bytes the store holds. It also reports whether that count is above a programmable threshold. Five sticky event flags complete the word: receive-ready, overflow, chip-select error, frame start and frame end. The sticky flags clear when the status word is read. An event that arrives in the same cycle as that read is kept.

The read side is a valid/ready stream. `rd_valid` is high whenever the store holds a byte, `rd_data` shows the oldest byte, and a cycle with both `rd_valid` and `rd_ready` high removes that byte. The write side has no ready: the shift engine cannot be stalled. A byte offered while the store is full, with no removal in the same cycle, is dropped and recorded as an overflow.

Top module: `spi_rx_status_unit`

## Requirements
- R1: Bytes leave through `rd_data` in the order they arrived. The store holds at most 4 bytes, and a cycle with `rd_valid` and `rd_ready` both high removes the oldest byte.
- R2: Status bits [10:8] give the number of stored bytes (0 to 4), and `rd_valid` is high exactly when that number is non-zero.
- R3: Status bit 11 is a live bit, not a sticky flag. It is 1 exactly when the stored count exceeds `thr_mode`+1, so `thr_mode` values 0, 1, 2 and 3 select thresholds of 1, 2, 3 and 4.
- R4: A byte offered while 4 bytes are stored, with no removal in the same cycle, is dropped. It sets status bit 7 (overflow), which clears on a status read.
- R5: Status bit 6 (receive-ready) is set when a byte is stored that brings the count to `thr_mode`+1 or more, provided `tim_mode` is 0 and `dma_en` is 0. It is never set while `dma_en` is 1, and it clears on a status read.
- R6: While `flush_ctl` is high, the count is 0 from the next cycle on. Offered bytes are discarded and removals are ignored. The overflow flag does not drive `irq` while `flush_ctl` is high.
- R7: `cs_n` passes through a two-stage synchronizer. A falling edge sets status bit 13 and a rising edge sets status bit 14, but only when `master_en`, `cont_en` and `csirq_en` are all 1. The flag appears 3 clock edges after `cs_n` changes.
- R8: A synchronized rising edge of `cs_n` while `mid_byte` is high sets status bit 12 (chip-select error), whatever the mode inputs are.
- R9: A flag event in the same cycle as `stat_rd` leaves that flag set. A status read with no event clears every sticky flag (bits 14, 13, 12, 7 and 6).
- R10: `irq` is the OR of bits 14, 13, 12 and 6, together with bit 7 when `flush_ctl` is low. Status bit 15 and bits [5:0] always read 0.
- R11: After reset the status word is 0x0000, `irq` is 0 and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | A finished received byte is present on `byte_data` this cycle |
| byte_data | input | 8 | Received byte |
| mid_byte | input | 1 | The shift engine has shifted part of a byte but not all of it |
| cs_n | input | 1 | Chip-select line, active low, asynchronous to `clk` |
| master_en | input | 1 | Master mode |
| cont_en | input | 1 | Continuous transfer mode |
| csirq_en | input | 1 | Enables the chip-select edge flags |
| dma_en | input | 1 | DMA mode; suppresses the receive-ready flag |
| tim_mode | input | 1 | Transfer-initiate mode; 1 suppresses the receive-ready flag |
| thr_mode | input | 2 | Threshold select; the threshold is `thr_mode`+1 bytes |
| flush_ctl | input | 1 | Empties the store and discards input while high |
| stat_rd | input | 1 | Status read strobe; clears the sticky flags |
| rd_ready | input | 1 | Reader accepts `rd_data` |
| rd_valid | output | 1 | The store holds at least one byte |
| rd_data | output | 8 | Oldest stored byte |
| status | output | 16 | Status word |
| irq | output | 1 | Level interrupt |

## Verification
Writes, removals and flush take effect at the next clock edge. The count, the live excess bit, the sticky flags and `irq` therefore change one edge after their stimulus, because the status word and `irq` are decoded from registers without further delay. Chip-select flags take three edges: two synchronizer stages, then the flag register. The bench drives inputs on the falling edge and reads outputs on the following falling edges. It checks the chip-select flags one edge before they are due, where they must still be clear, and again on the edge where they must be set. A status read is sampled in the cycle of the strobe, and its clearing effect is checked one edge later.

// File: rtl/spi_rxs_pkg.sv
package spi_rxs_pkg;

  typedef struct packed {
    logic cs_rise;
    logic cs_fall;
    logic cs_err;
    logic ovf;
    logic rxf;
  } rxs_flags_t;

  localparam int unsigned STAT_W = 16;
  localparam int unsigned CNT_FIELD_W = 3;

  function automatic logic [CNT_FIELD_W-1:0] thr_bytes(input logic [1:0] mode);
    return {1'b0, mode} + 3'd1;
  endfunction

endpackage

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  level,
  output logic [CNT_W-1:0]  level_nxt,
  output logic              wr_acc,
  output logic              ovf_evt
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic              full, empty, rd_fire;

  assign full    = (level == CNT_W'(DEPTH));
  assign empty   = (level == '0);
  assign rd_fire = rd_en && !empty && !flush;
  assign wr_acc  = wr_en && !flush && (!full || rd_fire);
  assign ovf_evt = wr_en && !flush && full && !rd_fire;
  assign rd_data = mem[rptr];

  always_comb begin
    if (flush) level_nxt = '0;
    else level_nxt = level + CNT_W'(wr_acc) - CNT_W'(rd_fire);
  end

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      level <= level_nxt;
      if (flush) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (wr_acc) wptr <= bump(wptr);
        if (rd_fire) rptr <= bump(rptr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wptr] <= wr_data;
  end

endmodule

// File: rtl/rxs_cs_detect.sv
module rxs_cs_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_in,
  output logic rise,
  output logic fall
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b1;
        else if (i == 0) sync_q[i] <= cs_in;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else last_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] && !last_q;
  assign fall = !sync_q[SYNC_STAGES-1] && last_q;

endmodule

// File: rtl/rxs_flags.sv
module rxs_flags
  import spi_rxs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  rxs_flags_t evt,
  output rxs_flags_t flg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg <= '0;
    else flg <= (clr ? rxs_flags_t'('0) : flg) | evt;
  end

endmodule

// File: rtl/spi_rx_status_unit.sv
module spi_rx_status_unit
  import spi_rxs_pkg::*;
#(
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              mid_byte,
  input  logic              cs_n,
  input  logic              master_en,
  input  logic              cont_en,
  input  logic              csirq_en,
  input  logic              dma_en,
  input  logic              tim_mode,
  input  logic [1:0]        thr_mode,
  input  logic              flush_ctl,
  input  logic              stat_rd,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [STAT_W-1:0] status,
  output logic              irq
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] level, level_nxt;
  logic             wr_acc, ovf_evt, cs_rise, cs_fall, edge_gate;
  logic [CNT_FIELD_W-1:0] cnt3, cnt3_nxt, thr;
  rxs_flags_t       evt, flg;

  rxs_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush_ctl),
    .wr_en(byte_valid), .wr_data(byte_data),
    .rd_en(rd_ready), .rd_data(rd_data),
    .level(level), .level_nxt(level_nxt),
    .wr_acc(wr_acc), .ovf_evt(ovf_evt)
  );

  rxs_cs_detect #(.SYNC_STAGES(SYNC_STAGES)) u_cs (
    .clk(clk), .rst_n(rst_n), .cs_in(cs_n), .rise(cs_rise), .fall(cs_fall)
  );

  assign cnt3      = CNT_FIELD_W'(level);
  assign cnt3_nxt  = CNT_FIELD_W'(level_nxt);
  assign thr       = thr_bytes(thr_mode);
  assign edge_gate = master_en && cont_en && csirq_en;

  always_comb begin
    evt.cs_rise = cs_rise && edge_gate;
    evt.cs_fall = cs_fall && edge_gate;
    evt.cs_err  = cs_rise && mid_byte;
    evt.ovf     = ovf_evt;
    evt.rxf     = wr_acc && !tim_mode && !dma_en && (cnt3_nxt >= thr);
  end

  rxs_flags u_flags (
    .clk(clk), .rst_n(rst_n), .clr(stat_rd), .evt(evt), .flg(flg)
  );

  assign rd_valid = (level != '0);

  assign status = {1'b0, flg.cs_rise, flg.cs_fall, flg.cs_err,
                   (cnt3 > thr), cnt3, flg.ovf, flg.rxf, 6'b0};

  assign irq = flg.cs_rise || flg.cs_fall || flg.cs_err || flg.rxf ||
               (flg.ovf && !flush_ctl);

endmodule

// File: rtl/spi_rx_status_unit_chk.sv
module spi_rx_status_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        byte_valid,
  input logic        flush_ctl,
  input logic        stat_rd,
  input logic        rd_ready,
  input logic [1:0]  thr_mode,
  input logic        rd_valid,
  input logic [15:0] status,
  input logic        irq
);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    status[10:8] <= 3'd4);

  a_r2_valid_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == (status[10:8] != 3'd0));

  a_r3_excess_live: assert property (@(posedge clk) disable iff (!rst_n)
    status[11] == (status[10:8] > ({1'b0, thr_mode} + 3'd1)));

  a_r4_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !flush_ctl && !rd_ready && status[10:8] == 3'd4) |=> status[7]);

  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ctl |=> (status[10:8] == 3'd0));

  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && byte_valid && !flush_ctl && !rd_ready && status[10:8] == 3'd4)
      |=> status[7]);

  a_r10_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    status[15] == 1'b0 && status[5:0] == 6'd0);

  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status[14] || status[13] || status[12] || status[6] ||
             (status[7] && !flush_ctl)));

endmodule

bind spi_rx_status_unit spi_rx_status_unit_chk u_chk (.*);

// File: tb/spi_rx_status_unit_test.sv
module spi_rx_status_unit_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_valid = 0, mid_byte = 0, cs_n = 1;
  logic [7:0] byte_data = 0;
  logic master_en = 0, cont_en = 0, csirq_en = 0, dma_en = 0, tim_mode = 0;
  logic [1:0] thr_mode = 2'd3;
  logic flush_ctl = 0, stat_rd = 0, rd_ready = 0;
  logic rd_valid, irq;
  logic [7:0] rd_data;
  logic [15:0] status;

  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  spi_rx_status_unit uut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .mid_byte(mid_byte), .cs_n(cs_n), .master_en(master_en), .cont_en(cont_en),
    .csirq_en(csirq_en), .dma_en(dma_en), .tim_mode(tim_mode), .thr_mode(thr_mode),
    .flush_ctl(flush_ctl), .stat_rd(stat_rd), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .status(status), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected < 20000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    byte_valid = 1; byte_data = d;
    tick(1);
    byte_valid = 0;
  endtask

  task automatic pop(output logic [7:0] d);
    d = rd_data; rd_ready = 1;
    tick(1);
    rd_ready = 0;
  endtask

  task automatic sread(output logic [15:0] s);
    s = status; stat_rd = 1;
    tick(1);
    stat_rd = 0;
  endtask

  task automatic do_flush();
    flush_ctl = 1; tick(1); flush_ctl = 0;
    begin logic [15:0] s; sread(s); end
  endtask

  task automatic t_reset();
    chk("R11 status", status, 16'h0000);
    chk("R11 irq", {15'b0, irq}, 16'h0);
    chk("R11 rd_valid", {15'b0, rd_valid}, 16'h0);
  endtask

  task automatic t_order();
    logic [7:0] d;
    dma_en = 1; thr_mode = 2'd3;
    push(8'hA1); push(8'hB2); push(8'hC3);
    chk("R2 count 3", {13'b0, status[10:8]}, 16'd3);
    chk("R2 rd_valid", {15'b0, rd_valid}, 16'd1);
    pop(d); chk("R1 first", {8'b0, d}, 16'h00A1);
    push(8'hD4); push(8'hE5);
    chk("R2 count 4", {13'b0, status[10:8]}, 16'd4);
    pop(d); chk("R1 second", {8'b0, d}, 16'h00B2);
    pop(d); chk("R1 third", {8'b0, d}, 16'h00C3);
    pop(d); chk("R1 fourth", {8'b0, d}, 16'h00D4);
    pop(d); chk("R1 wrap", {8'b0, d}, 16'h00E5);
    chk("R2 empty", {13'b0, status[10:8]}, 16'd0);
    pop(d);
    chk("R1 pop on empty", {13'b0, status[10:8]}, 16'd0);
  endtask

  task automatic t_excess();
    dma_en = 1; thr_mode = 2'd0;
    push(8'h01);
    chk("R3 mode0 cnt1", {15'b0, status[11]}, 16'd0);
    push(8'h02);
    chk("R3 mode0 cnt2", {15'b0, status[11]}, 16'd1);
    thr_mode = 2'd2; #1;
    chk("R3 mode2 cnt2", {15'b0, status[11]}, 16'd0);
    push(8'h03); push(8'h04);
    chk("R3 mode2 cnt4", {15'b0, status[11]}, 16'd1);
    thr_mode = 2'd3; #1;
    chk("R3 mode3 cnt4", {15'b0, status[11]}, 16'd0);
    do_flush();
  endtask

  task automatic t_overflow();
    logic [15:0] s; logic [7:0] d;
    dma_en = 1; thr_mode = 2'd3;
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    chk("R4 no ovf at full", {15'b0, status[7]}, 16'd0);
    push(8'h55);
    chk("R4 ovf set", {15'b0, status[7]}, 16'd1);
    chk("R10 irq from ovf", {15'b0, irq}, 16'd1);
    sread(s);
    chk("R4 read sees ovf", {15'b0, s[7]}, 16'd1);
    chk("R9 read clears ovf", {15'b0, status[7]}, 16'd0);
    pop(d); chk("R4 dropped byte", {8'b0, d}, 16'h0011);
    pop(d); pop(d); pop(d); chk("R4 last kept", {8'b0, d}, 16'h0044);
    chk("R4 count after drain", {13'b0, status[10:8]}, 16'd0);
  endtask

  task automatic t_rxflag();
    logic [15:0] s;
    dma_en = 0; tim_mode = 0; thr_mode = 2'd1;
    push(8'h01);
    chk("R5 below thr", {15'b0, status[6]}, 16'd0);
    push(8'h02);
    chk("R5 at thr", {15'b0, status[6]}, 16'd1);
    chk("R10 irq rx", {15'b0, irq}, 16'd1);
    sread(s);
    chk("R5 cleared by read", {15'b0, status[6]}, 16'd0);
    do_flush();
    dma_en = 1;
    push(8'h03); push(8'h04);
    chk("R5 dma blocks", {15'b0, status[6]}, 16'd0);
    chk("R5 dma irq", {15'b0, irq}, 16'd0);
    do_flush();
    dma_en = 0; tim_mode = 1;
    push(8'h05); push(8'h06);
    chk("R5 tim blocks", {15'b0, status[6]}, 16'd0);
    tim_mode = 0;
    do_flush();
  endtask

  task automatic t_flush();
    dma_en = 1; thr_mode = 2'd3;
    push(8'h01); push(8'h02); push(8'h03); push(8'h04); push(8'h05);
    chk("R6 irq before flush", {15'b0, irq}, 16'd1);
    flush_ctl = 1; #1;
    chk("R6 ovf irq masked", {15'b0, irq}, 16'd0);
    tick(1);
    chk("R6 emptied", {13'b0, status[10:8]}, 16'd0);
    chk("R6 ovf flag held", {15'b0, status[7]}, 16'd1);
    push(8'h09);
    chk("R6 byte discarded", {13'b0, status[10:8]}, 16'd0);
    flush_ctl = 0; #1;
    chk("R6 count stays 0", {13'b0, status[10:8]}, 16'd0);
    do_flush();
  endtask

  task automatic t_cs_edges();
    logic [15:0] s;
    master_en = 1; cont_en = 1; csirq_en = 1; dma_en = 1;
    cs_n = 0;
    tick(2);
    chk("R7 fall not yet", {15'b0, status[13]}, 16'd0);
    tick(1);
    chk("R7 fall flag", {15'b0, status[13]}, 16'd1);
    chk("R10 irq cs", {15'b0, irq}, 16'd1);
    sread(s);
    cs_n = 1;
    tick(2);
    chk("R7 rise not yet", {15'b0, status[14]}, 16'd0);
    tick(1);
    chk("R7 rise flag", {15'b0, status[14]}, 16'd1);
    chk("R7 no cs err", {15'b0, status[12]}, 16'd0);
    sread(s);
    chk("R9 cleared", status, 16'h0000);
    csirq_en = 0;
    cs_n = 0; tick(4); cs_n = 1; tick(4);
    chk("R7 gated off", {14'b0, status[14:13]}, 16'd0);
    chk("R7 gated irq", {15'b0, irq}, 16'd0);
  endtask

  task automatic t_cs_err();
    logic [15:0] s;
    master_en = 0; cont_en = 0; csirq_en = 0;
    cs_n = 0; tick(4);
    mid_byte = 1; cs_n = 1; tick(3);
    chk("R8 cs error", {15'b0, status[12]}, 16'd1);
    chk("R8 irq", {15'b0, irq}, 16'd1);
    mid_byte = 0;
    sread(s);
    cs_n = 0; tick(4); cs_n = 1; tick(4);
    chk("R8 clean end", {15'b0, status[12]}, 16'd0);
  endtask

  task automatic t_set_wins();
    logic [15:0] s;
    dma_en = 1; thr_mode = 2'd3;
    push(8'h01); push(8'h02); push(8'h03); push(8'h04);
    byte_valid = 1; byte_data = 8'h05; stat_rd = 1;
    tick(1);
    byte_valid = 0; stat_rd = 0;
    chk("R9 set wins", {15'b0, status[7]}, 16'd1);
    sread(s);
    chk("R9 later read clears", {15'b0, status[7]}, 16'd0);
    do_flush();
  endtask

  initial begin
    tick(2);
    t_reset();
    rst_n = 1;
    tick(1);
    t_order();
    t_excess();
    t_overflow();
    t_rxflag();
    t_flush();
    t_cs_edges();
    t_cs_err();
    t_set_wins();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule